// File: doc/BRIEF.md
# SCSI Adapter DMA Register Engine

This block keeps the bus-master DMA registers of a SCSI host adapter. Software programs three start values (byte count, memory address, descriptor-list address) and then writes a command word. The command's low two bits pick an action. A start action copies the three start values into working copies in one edge and clears the status. The transfer machinery outside this block reports each data move as a step with a byte length and a direction. The block clips the step to the bytes remaining, counts the working registers and flags completion in a status register.

The status error, abort and done flags can be cleared in two ways. A bus-control register bit selects between them. In read-to-clear mode, an accepted status read clears them. In write-one-to-clear mode, a status write clears each flag whose bit is one in the written word. A status read always shows the SCSI core's interrupt line in bit 4. Descriptor-list mode and diagnostic mode are held as command bits and brought out as flags, but no descriptor-list transfer is performed here.

Top module: `scsi_dma_regs`

## Requirements
- R1: After reset: command 0, working count 0, working address 0xFFFFFFFF, working descriptor address 0xFFFFFFFD, status 0, `dma_en` 0. Register word indices: 0 command, 1 start count, 2 start address, 3 start descriptor address, 4 status, 5 working count, 6 working address, 7 working descriptor address, 8 bus control.
- R2: Command bits [1:0] = 3 (start) sets `dma_en`. Command bits [1:0] = 0 (idle) clears `dma_en`.
- R3: Command bits [1:0] = 2 (abort) raises `abort_req` for exactly the one cycle after the write and leaves `dma_en` unchanged. Command bits [1:0] = 1 (blast) changes neither `dma_en`, the status nor the working count.
- R4: Command bit 7 drives `dir_to_mem` (1 = device to memory), bit 6 drives `done_irq_en`, bit 5 drives `scsi_irq_en`, bit 4 drives `desc_mode` and bit 2 drives `diag_mode`.
- R5: A start command loads the working count, working address and working descriptor address from the start registers, and clears all six status bits, all in one edge.
- R6: An accepted step moves min(`step_len`, working count) bytes, shown on `step_moved` in the same cycle. It decreases the working count by that amount and increases the working address by it.
- R7: A step that leaves the working count at zero sets status bit 3 (done).
- R8: A step whose `step_to_mem` differs from command bit 7 is rejected. `step_moved` is 0 and no register changes.
- R9: With bus-control bit 24 set, a status write clears each of status bits 1 (error), 2 (abort) and 3 (done) whose written bit is one. Status reads do not clear them in this mode.
- R10: With bus-control bit 24 clear, an accepted status read returns the status and then clears bits 1 to 3. Status writes are ignored in this mode.
- R11: While `core_irq` is high, a status read returns bit 4 set.
- R12: A `cmd_done_in` pulse forces the working count to 0 and sets the done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (enables read side effects) |
| reg_idx | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| step_valid | input | 1 | A transfer step is reported this cycle |
| step_to_mem | input | 1 | Step direction, 1 = device to memory |
| step_len | input | 32 | Requested step length in bytes |
| step_moved | output | 32 | Bytes actually moved by this step |
| core_irq | input | 1 | SCSI core interrupt line |
| cmd_done_in | input | 1 | Command-complete pulse |
| dma_en | output | 1 | DMA enabled |
| abort_req | output | 1 | One-cycle request to cancel the current transfer |
| dir_to_mem | output | 1 | Command direction bit |
| done_irq_en | output | 1 | Done interrupt enable bit |
| scsi_irq_en | output | 1 | SCSI interrupt enable bit |
| desc_mode | output | 1 | Descriptor-list mode bit |
| diag_mode | output | 1 | Diagnostic mode bit |

## Verification
On every cycle, the checker enforces five rules: a start loads the working copies, completion zeroes the count and sets done, a read in read-to-clear mode clears the flags, a wrong-direction step leaves the counters still, and an accepted step keeps the sum of count and address constant. It also checks that a status read reflects the interrupt line and that an abort write yields the request pulse. Only the bench scenarios show the exact reset values, clipping of an oversized step, that a write in read-to-clear mode is ignored, that a blast does nothing, and that flags persist across reads in write-one-to-clear mode.

// File: rtl/scsi_dma_pkg.sv
package scsi_dma_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_BLAST = 2'd1,
        ACT_ABORT = 2'd2,
        ACT_START = 2'd3
    } dma_act_e;

    typedef struct packed {
        logic     to_mem;
        logic     done_ie;
        logic     scsi_ie;
        logic     desc_mode;
        logic     spare;
        logic     diag;
        dma_act_e act;
    } dma_cmd_t;

    localparam int unsigned ST_W      = 6;
    localparam int unsigned ST_ERR    = 1;
    localparam int unsigned ST_ABT    = 2;
    localparam int unsigned ST_DONE   = 3;
    localparam int unsigned ST_SCSI   = 4;
    localparam logic [ST_W-1:0] ST_CLR_MASK = 6'b00_1110;

    localparam int unsigned CTL_W1C_BIT = 24;

    localparam logic [3:0] IDX_CMD   = 4'd0;
    localparam logic [3:0] IDX_SCNT  = 4'd1;
    localparam logic [3:0] IDX_SADR  = 4'd2;
    localparam logic [3:0] IDX_SDSC  = 4'd3;
    localparam logic [3:0] IDX_STAT  = 4'd4;
    localparam logic [3:0] IDX_WCNT  = 4'd5;
    localparam logic [3:0] IDX_WADR  = 4'd6;
    localparam logic [3:0] IDX_WDSC  = 4'd7;
    localparam logic [3:0] IDX_CTL   = 4'd8;

    function automatic logic [31:0] clip_len(input logic [31:0] req, input logic [31:0] left);
        return (req < left) ? req : left;
    endfunction

endpackage

// File: rtl/dma_cmd_reg.sv
module dma_cmd_reg
    import scsi_dma_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_we,
    input  logic [7:0] cmd_wdata,
    output dma_cmd_t cmd,
    output logic     start_now,
    output logic     dma_en,
    output logic     abort_req
);
    dma_cmd_t new_cmd;
    assign new_cmd   = dma_cmd_t'(cmd_wdata);
    assign start_now = cmd_we && (new_cmd.act == ACT_START);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd       <= '0;
            dma_en    <= 1'b0;
            abort_req <= 1'b0;
        end else begin
            abort_req <= 1'b0;
            if (cmd_we) begin
                cmd <= new_cmd;
                unique case (new_cmd.act)
                    ACT_IDLE:  dma_en    <= 1'b0;
                    ACT_BLAST: ;
                    ACT_ABORT: abort_req <= 1'b1;
                    ACT_START: dma_en    <= 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr
    import scsi_dma_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_now,
    input  logic [DATA_W-1:0] start_cnt,
    input  logic [DATA_W-1:0] start_adr,
    input  logic [DATA_W-1:0] start_dsc,
    input  logic              step_valid,
    input  logic              step_to_mem,
    input  logic              cmd_to_mem,
    input  logic [DATA_W-1:0] step_len,
    input  logic              complete,
    output logic [DATA_W-1:0] wcnt,
    output logic [DATA_W-1:0] wadr,
    output logic [DATA_W-1:0] wdsc,
    output logic [DATA_W-1:0] moved,
    output logic              hit_zero
);
    localparam logic [DATA_W-1:0] ADR_RST = '1;
    localparam logic [DATA_W-1:0] DSC_RST = ~DATA_W'(2);

    logic accept;
    assign accept   = step_valid && (step_to_mem == cmd_to_mem);
    assign moved    = accept ? DATA_W'(clip_len(32'(step_len), 32'(wcnt))) : '0;
    assign hit_zero = accept && !start_now && (wcnt == moved);

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
            wadr <= ADR_RST;
            wdsc <= DSC_RST;
        end else if (start_now) begin
            wcnt <= start_cnt;
            wadr <= start_adr;
            wdsc <= start_dsc;
        end else if (complete) begin
            wcnt <= '0;
        end else if (accept) begin
            wcnt <= wcnt - moved;
            wadr <= wadr + moved;
        end
    end
endmodule

// File: rtl/dma_status_reg.sv
module dma_status_reg
    import scsi_dma_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start_now,
    input  logic            rd_clr,
    input  logic            wr_clr,
    input  logic [ST_W-1:0] wr_mask,
    input  logic            set_done,
    output logic [ST_W-1:0] status
);
    logic [ST_W-1:0] nxt;

    always_comb begin
        nxt = status;
        if (rd_clr) nxt = nxt & ~ST_CLR_MASK;
        if (wr_clr) nxt = nxt & ~(wr_mask & ST_CLR_MASK);
        if (set_done) nxt[ST_DONE] = 1'b1;
        if (start_now) nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= nxt;
    end
endmodule

// File: rtl/scsi_dma_regs.sv
module scsi_dma_regs
    import scsi_dma_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              step_valid,
    input  logic              step_to_mem,
    input  logic [DATA_W-1:0] step_len,
    output logic [DATA_W-1:0] step_moved,
    input  logic              core_irq,
    input  logic              cmd_done_in,
    output logic              dma_en,
    output logic              abort_req,
    output logic              dir_to_mem,
    output logic              done_irq_en,
    output logic              scsi_irq_en,
    output logic              desc_mode,
    output logic              diag_mode
);
    dma_cmd_t          cmd;
    logic              start_now;
    logic [DATA_W-1:0] start_cnt, start_adr, start_dsc, bus_ctl;
    logic [DATA_W-1:0] wcnt, wadr, wdsc;
    logic [ST_W-1:0]   status, status_view;
    logic              hit_zero, w1c_mode;

    function automatic logic hit(input logic [IDX_W-1:0] idx, input logic [3:0] want);
        return idx == IDX_W'(want);
    endfunction

    assign w1c_mode = bus_ctl[CTL_W1C_BIT];

    dma_cmd_reg u_cmd (
        .clk(clk), .rst(rst),
        .cmd_we(reg_wr && hit(reg_idx, IDX_CMD)),
        .cmd_wdata(reg_wdata[7:0]),
        .cmd(cmd), .start_now(start_now),
        .dma_en(dma_en), .abort_req(abort_req)
    );

    dma_xfer_ctr #(.DATA_W(DATA_W)) u_ctr (
        .clk(clk), .rst(rst), .start_now(start_now),
        .start_cnt(start_cnt), .start_adr(start_adr), .start_dsc(start_dsc),
        .step_valid(step_valid), .step_to_mem(step_to_mem),
        .cmd_to_mem(cmd.to_mem), .step_len(step_len),
        .complete(cmd_done_in),
        .wcnt(wcnt), .wadr(wadr), .wdsc(wdsc),
        .moved(step_moved), .hit_zero(hit_zero)
    );

    dma_status_reg u_stat (
        .clk(clk), .rst(rst), .start_now(start_now),
        .rd_clr(reg_rd && hit(reg_idx, IDX_STAT) && !w1c_mode),
        .wr_clr(reg_wr && hit(reg_idx, IDX_STAT) && w1c_mode),
        .wr_mask(reg_wdata[ST_W-1:0]),
        .set_done(hit_zero || cmd_done_in),
        .status(status)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            start_cnt <= '0;
            start_adr <= '0;
            start_dsc <= '0;
            bus_ctl   <= '0;
        end else if (reg_wr) begin
            if (hit(reg_idx, IDX_SCNT)) start_cnt <= reg_wdata;
            if (hit(reg_idx, IDX_SADR)) start_adr <= reg_wdata;
            if (hit(reg_idx, IDX_SDSC)) start_dsc <= reg_wdata;
            if (hit(reg_idx, IDX_CTL))  bus_ctl   <= reg_wdata;
        end
    end

    always_comb begin
        status_view = status;
        if (core_irq) status_view[ST_SCSI] = 1'b1;
    end

    always_comb begin
        reg_rdata = '0;
        if      (hit(reg_idx, IDX_CMD))  reg_rdata = DATA_W'(cmd);
        else if (hit(reg_idx, IDX_SCNT)) reg_rdata = start_cnt;
        else if (hit(reg_idx, IDX_SADR)) reg_rdata = start_adr;
        else if (hit(reg_idx, IDX_SDSC)) reg_rdata = start_dsc;
        else if (hit(reg_idx, IDX_STAT)) reg_rdata = DATA_W'(status_view);
        else if (hit(reg_idx, IDX_WCNT)) reg_rdata = wcnt;
        else if (hit(reg_idx, IDX_WADR)) reg_rdata = wadr;
        else if (hit(reg_idx, IDX_WDSC)) reg_rdata = wdsc;
        else if (hit(reg_idx, IDX_CTL))  reg_rdata = bus_ctl;
    end

    assign dir_to_mem  = cmd.to_mem;
    assign done_irq_en = cmd.done_ie;
    assign scsi_irq_en = cmd.scsi_ie;
    assign desc_mode   = cmd.desc_mode;
    assign diag_mode   = cmd.diag;
endmodule

// File: rtl/scsi_dma_regs_chk.sv
module scsi_dma_regs_chk
    import scsi_dma_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              step_valid,
    input logic              step_to_mem,
    input logic              core_irq,
    input logic              cmd_done_in,
    input logic              dir_to_mem,
    input logic              abort_req,
    input logic              start_now,
    input logic              w1c_mode,
    input logic [DATA_W-1:0] start_cnt,
    input logic [DATA_W-1:0] start_adr,
    input logic [DATA_W-1:0] wcnt,
    input logic [DATA_W-1:0] wadr,
    input logic [ST_W-1:0]   status
);
    logic stat_sel, cmd_sel;
    assign stat_sel = reg_idx == IDX_W'(IDX_STAT);
    assign cmd_sel  = reg_idx == IDX_W'(IDX_CMD);

    // R5
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start_now |=> (wcnt == $past(start_cnt)) && (wadr == $past(start_adr)) && (status == '0));

    // R12
    complete_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_done_in && !start_now) |=> (wcnt == '0) && status[ST_DONE]);

    // R10
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && stat_sel && !w1c_mode && !step_valid && !cmd_done_in) |=> (status & ST_CLR_MASK) == '0);

    // R8
    dir_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (step_valid && (step_to_mem != dir_to_mem) && !start_now && !cmd_done_in)
        |=> $stable(wcnt) && $stable(wadr));

    // R6
    sum_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (step_valid && (step_to_mem == dir_to_mem) && !start_now && !cmd_done_in)
        |=> (DATA_W'(wcnt + wadr) == $past(DATA_W'(wcnt + wadr))));

    // R11
    irq_view_chk: assert property (@(posedge clk) disable iff (rst)
        (core_irq && stat_sel) |-> reg_rdata[ST_SCSI]);

    // R3
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && cmd_sel && (reg_wdata[1:0] == 2'd2)) |=> abort_req);
endmodule

bind scsi_dma_regs scsi_dma_regs_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step_valid(step_valid),
    .step_to_mem(step_to_mem), .core_irq(core_irq), .cmd_done_in(cmd_done_in),
    .dir_to_mem(dir_to_mem), .abort_req(abort_req), .start_now(start_now),
    .w1c_mode(w1c_mode), .start_cnt(start_cnt), .start_adr(start_adr),
    .wcnt(wcnt), .wadr(wadr), .status(status)
);

// File: tb/scsi_dma_regs_bench.sv
`timescale 1ns/1ps
module scsi_dma_regs_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        step_valid = 1'b0, step_to_mem = 1'b0;
    logic [31:0] step_len = '0, step_moved;
    logic        core_irq = 1'b0, cmd_done_in = 1'b0;
    logic        dma_en, abort_req, dir_to_mem, done_irq_en, scsi_irq_en, desc_mode, diag_mode;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    scsi_dma_regs u_scsi_dma_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .step_valid(step_valid),
        .step_to_mem(step_to_mem), .step_len(step_len), .step_moved(step_moved),
        .core_irq(core_irq), .cmd_done_in(cmd_done_in), .dma_en(dma_en),
        .abort_req(abort_req), .dir_to_mem(dir_to_mem), .done_irq_en(done_irq_en),
        .scsi_irq_en(scsi_irq_en), .desc_mode(desc_mode), .diag_mode(diag_mode)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] val);
        @(negedge clk);
        reg_rd = 1'b1; reg_idx = idx;
        #1 val = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic step(input logic to_mem, input logic [31:0] len, output logic [31:0] mv);
        @(negedge clk);
        step_valid = 1'b1; step_to_mem = to_mem; step_len = len;
        #1 mv = step_moved;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        cmd_done_in = 1'b1;
        @(negedge clk);
        cmd_done_in = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 dma_en", 32'(dma_en), 0);
        rd(4'd0, v); chk("R1 cmd", v, 0);
        rd(4'd5, v); chk("R1 wcnt", v, 0);
        rd(4'd6, v); chk("R1 wadr", v, 32'hFFFF_FFFF);
        rd(4'd7, v); chk("R1 wdsc", v, 32'hFFFF_FFFD);
        rd(4'd4, v); chk("R1 status", v, 0);
    endtask

    task automatic t_start();
        logic [31:0] v;
        wr(4'd1, 32'd100);
        wr(4'd2, 32'h0000_1000);
        wr(4'd3, 32'h0000_2000);
        wr(4'd0, 32'h83);
        chk("R2 start enables", 32'(dma_en), 1);
        chk("R4 dir_to_mem", 32'(dir_to_mem), 1);
        rd(4'd5, v); chk("R5 wcnt load", v, 100);
        rd(4'd6, v); chk("R5 wadr load", v, 32'h1000);
        rd(4'd7, v); chk("R5 wdsc load", v, 32'h2000);
    endtask

    task automatic t_steps();
        logic [31:0] v, mv;
        step(1'b1, 32'd40, mv); chk("R6 moved", mv, 40);
        rd(4'd5, v); chk("R6 wcnt dec", v, 60);
        rd(4'd6, v); chk("R6 wadr inc", v, 32'h1028);
        step(1'b0, 32'd10, mv); chk("R8 rejected moved", mv, 0);
        rd(4'd5, v); chk("R8 wcnt kept", v, 60);
        rd(4'd6, v); chk("R8 wadr kept", v, 32'h1028);
        step(1'b1, 32'd100, mv); chk("R6 clipped", mv, 60);
        rd(4'd5, v); chk("R7 wcnt zero", v, 0);
        rd(4'd6, v); chk("R6 wadr end", v, 32'h1064);
        rd(4'd4, v); chk("R7 done set", v, 32'h08);
        rd(4'd4, v); chk("R10 read cleared", v, 0);
    endtask

    task automatic t_irq_and_rdclr();
        logic [31:0] v;
        @(negedge clk); core_irq = 1'b1;
        rd(4'd4, v); chk("R11 irq bit", v, 32'h10);
        @(negedge clk); core_irq = 1'b0;
        pulse_done();
        wr(4'd4, 32'h0E);
        rd(4'd4, v); chk("R10 write ignored", v, 32'h08);
        rd(4'd4, v); chk("R10 cleared", v, 0);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(4'd8, 32'h0100_0000);
        pulse_done();
        rd(4'd5, v); chk("R12 wcnt zero", v, 0);
        rd(4'd4, v); chk("R12 done", v, 32'h08);
        rd(4'd4, v); chk("R9 read keeps", v, 32'h08);
        wr(4'd4, 32'h02);
        rd(4'd4, v); chk("R9 other bit no clear", v, 32'h08);
        wr(4'd4, 32'h08);
        rd(4'd4, v); chk("R9 w1c done", v, 0);
        pulse_done();
        wr(4'd0, 32'h83);
        rd(4'd4, v); chk("R5 start clears status", v, 0);
        rd(4'd5, v); chk("R5 reload wcnt", v, 100);
    endtask

    task automatic t_cmds();
        logic [31:0] v;
        wr(4'd0, 32'h82);
        chk("R3 abort pulse", 32'(abort_req), 1);
        chk("R3 abort keeps en", 32'(dma_en), 1);
        @(negedge clk);
        chk("R3 abort one cycle", 32'(abort_req), 0);
        wr(4'd0, 32'h81);
        chk("R3 blast en", 32'(dma_en), 1);
        rd(4'd5, v); chk("R3 blast wcnt", v, 100);
        rd(4'd4, v); chk("R3 blast status", v, 0);
        wr(4'd0, 32'h74);
        chk("R2 idle disables", 32'(dma_en), 0);
        chk("R4 flags", {27'd0, dir_to_mem, done_irq_en, scsi_irq_en, desc_mode, diag_mode}, 32'h0F);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_start();
        t_steps();
        t_irq_and_rdclr();
        t_w1c();
        t_cmds();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule